// File: doc/BRIEF.md
# Reciprocal-Refinement Significand Divider

This unit divides one normalized 24-bit significand by another and returns a normalized 24-bit quotient rounded to nearest. It does not use a digit recurrence. A 16-entry seed table indexed by the leading fraction bits of the divisor supplies a rough reciprocal. A single multiply-accumulate unit, shared over time, then refines that estimate by Newton steps of the form t + (1 - t*y)*t. The same unit multiplies the refined reciprocal by the dividend to give a tentative quotient. It then forms the exact remainder dividend - quotient*divisor without any rounding, and that remainder moves the tentative quotient by one unit in the last place up or down and decides how to round.

Exponent handling, special values, subnormal inputs and directed rounding are left to the surrounding floating-point unit. So that the exponent logic can adjust by one, the block reports whether the dividend was smaller than the divisor. A caller presents both operands with a one-cycle start pulse while the unit is idle. It then waits for the one-cycle done pulse, after which the quotient, the adjust flag and the inexact flag stay valid until the next result.

Top module: `recip_divider`

## Requirements
- R1: After a synchronous active-low reset, busy, done, below, inexact and quo are all 0.
- R2: The operands have bit 23 set (value bit/2^23 in [1,2)). The output below is 1 exactly when x_sig < y_sig. The true quotient is then quo/2^24, and otherwise it is quo/2^23. quo always has bit 23 set when done is high.
- R3: quo equals the integer nearest to N/y_sig, where N = x_sig*2^23 when below is 0 and N = x_sig*2^24 when below is 1. The error is therefore at most half a unit in the last place.
- R4: Operand pairs whose quotient is exactly representable, such as equal operands or a divisor of 0x800000, return that exact value with inexact at 0.
- R5: inexact is 1 exactly when N is not divisible by y_sig, that is, when the exact remainder is nonzero.
- R6: done is high for exactly one cycle. It rises on the 9th rising edge after the edge that samples start (2*ITERS+3 edges with ITERS=3 refinement steps).
- R7: busy is 1 from the edge after an accepted start up to the edge that raises done, and busy is 0 while done is high.
- R8: A start pulse arriving while busy is 1 is ignored. It produces no extra done, and the running division returns the result for its original operands.
- R9: quo, below and inexact change only on the edge that raises done. Between results they hold even when the operand inputs change.
- R10: Every seed-table entry is exercised: divisors from all 16 values of y_sig[22:19] return correctly rounded quotients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| x_sig | input | 24 | Dividend significand, bit 23 set |
| y_sig | input | 24 | Divisor significand, bit 23 set |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| quo | output | 24 | Rounded quotient significand |
| below | output | 1 | Dividend was smaller than divisor; exponent needs minus one |
| inexact | output | 1 | Exact remainder was nonzero |

## Verification
Each division's results are due on the 9th rising edge after the edge that sampled start: one load edge, two edges for each of the three refinement steps, then one edge each for the quotient, the remainder and the final correction. The driver stamps each expected item with the cycle number of its start edge. The monitor samples on the falling edge when done is high and checks that exactly 9 edges have passed, as well as checking the quotient, the adjust flag and the inexact flag. Ignored starts and held results are checked by watching the outputs over the following idle cycles for stray done pulses or changed values.

// File: rtl/recip_div_pkg.sv
// Shared definitions for the reciprocal-refinement divider.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package recip_div_pkg;

    // Sequencer phases; each phase occupies one cycle of the shared MAC.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_ERR,    // MAC forms the reciprocal error 1 - t*y
        ST_UPD,    // MAC forms t + err*t
        ST_QUO,    // MAC forms t*x
        ST_REM,    // MAC forms x - q*y exactly
        ST_FIX     // correct, round and publish
    } div_state_t;

endpackage

// File: rtl/recip_seed_rom.sv
// Seed reciprocal table.
// What: maps the leading IDX_W fraction bits of the divisor to an SEED_W-bit
//       reciprocal estimate, value seed/2^SEED_W, of the interval midpoint.
// Assumes: divisor in [1,2), so every entry is below 2^SEED_W. Entries are
//          computed at elaboration, not written out.
module recip_seed_rom #(
    parameter int IDX_W  = 4,
    parameter int SEED_W = 8
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [SEED_W-1:0] seed
);
    localparam int ENTRIES = 1 << IDX_W;

    // Rounded 2^SEED_W / (1 + (2i+1)/2^(IDX_W+1)).
    function automatic int seed_calc(input int i);
        int num;
        int den;
        num = 1 << (SEED_W + IDX_W + 1);
        den = (1 << (IDX_W + 1)) + 2 * i + 1;
        return (2 * num + den) / (2 * den);
    endfunction

    logic [SEED_W-1:0] table_q [ENTRIES];

    // One constant per entry, built by a generate loop.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign table_q[i] = SEED_W'(seed_calc(i));
    end

    assign seed = table_q[idx];

endmodule

// File: rtl/recip_mac.sv
// Signed multiply-accumulate with no intermediate rounding.
// What: res = acc + a*b at full 2W-bit width.
// Assumes: the caller keeps the true result within 2W signed bits.
module recip_mac #(
    parameter int W = 36
) (
    input  logic signed [W-1:0]   a,
    input  logic signed [W-1:0]   b,
    input  logic signed [2*W-1:0] acc,
    output logic signed [2*W-1:0] res
);
    logic signed [2*W-1:0] a_ext;
    logic signed [2*W-1:0] b_ext;

    // Sign-extend both factors to product width.
    assign a_ext = {{W{a[W-1]}}, a};
    assign b_ext = {{W{b[W-1]}}, b};

    // Single exact product plus addend.
    assign res = acc + a_ext * b_ext;

endmodule

// File: rtl/recip_round.sv
// Quotient correction and round-to-nearest.
// What: takes a tentative quotient qt and its exact remainder rem = N - qt*y.
//       A negative remainder steps qt down, and a remainder >= y steps it up.
//       Twice the corrected remainder is then compared with y to round
//       (ties to the even neighbour).
// Assumes: qt is within one ulp of floor(N/y); the rounded value fits SIG_W bits.
module recip_round #(
    parameter int SIG_W = 24,
    parameter int REM_W = 28
) (
    input  logic [SIG_W:0]           qt,
    input  logic signed [REM_W-1:0]  rem,
    input  logic [SIG_W-1:0]         dvsr,
    output logic [SIG_W-1:0]         quo,
    output logic                     inexact,
    output logic                     rem_ok
);
    logic signed [REM_W-1:0] y_ext;
    logic signed [REM_W-1:0] r_fix;
    logic signed [REM_W-1:0] r_dbl;
    logic [SIG_W:0]          q_fix;
    logic [SIG_W:0]          q_rnd;
    logic                    rnd_up;
    logic                    unused_top;

    assign y_ext = {{(REM_W-SIG_W){1'b0}}, dvsr};

    // Step the tentative quotient so the remainder lands in [0, y).
    always_comb begin
        if (rem < 0) begin
            q_fix = qt - 1'b1;
            r_fix = rem + y_ext;
        end else if (rem >= y_ext) begin
            q_fix = qt + 1'b1;
            r_fix = rem - y_ext;
        end else begin
            q_fix = qt;
            r_fix = rem;
        end
    end

    // Nearest rounding: round up above half, ties to the even neighbour.
    always_comb begin
        r_dbl  = r_fix <<< 1;
        rnd_up = (r_dbl > y_ext) || ((r_dbl == y_ext) && q_fix[0]);
        q_rnd  = q_fix + {{SIG_W{1'b0}}, rnd_up};
    end

    assign quo        = q_rnd[SIG_W-1:0];
    assign unused_top = q_rnd[SIG_W];
    assign inexact    = (r_fix != '0);
    assign rem_ok     = (r_fix >= 0) && (r_fix < y_ext);

endmodule

// File: rtl/recip_divider.sv
// Reciprocal-refinement significand divider (top).
// What: divides normalized significands x/y. It seeds 1/y from a table, runs
//       ITERS Newton steps on one shared MAC, forms q = t*x, then the exact
//       remainder, and corrects and rounds to nearest.
// Assumes: x_sig and y_sig have their top bit set; start is honoured only when
//          busy is low. Latency is 2*ITERS+3 edges from the start edge.
module recip_divider
    import recip_div_pkg::*;
#(
    parameter int SIG_W  = 24,
    parameter int FRAC_F = 32,
    parameter int ITERS  = 3,
    parameter int IDX_W  = 4,
    parameter int SEED_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SIG_W-1:0] x_sig,
    input  logic [SIG_W-1:0] y_sig,
    output logic             busy,
    output logic             done,
    output logic [SIG_W-1:0] quo,
    output logic             below,
    output logic             inexact
);
    localparam int MAC_W  = FRAC_F + 4;
    localparam int PROD_W = 2 * MAC_W;
    localparam int REM_W  = SIG_W + 4;
    localparam int CNT_W  = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(ITERS - 1);
    localparam logic signed [PROD_W-1:0] ONE_ERR =
        {{(PROD_W-1){1'b0}}, 1'b1} << (FRAC_F + SIG_W - 1);

    div_state_t              state;
    logic [CNT_W-1:0]        iter_q;
    logic [SIG_W:0]          x_q;
    logic [SIG_W-1:0]        y_q;
    logic                    below_q;
    logic signed [MAC_W-1:0] t_q;
    logic signed [MAC_W-1:0] e_q;
    logic [SIG_W:0]          qt_q;
    logic signed [REM_W-1:0] rem_q;

    logic [SEED_W-1:0]        seed;
    logic signed [MAC_W-1:0]  mac_a;
    logic signed [MAC_W-1:0]  mac_b;
    logic signed [PROD_W-1:0] mac_acc;
    logic signed [PROD_W-1:0] mac_res;
    logic signed [PROD_W-1:0] sh_err;
    logic signed [PROD_W-1:0] sh_upd;
    logic signed [MAC_W-1:0]  y_neg;
    logic [SIG_W-1:0]         fix_quo;
    logic                     fix_inexact;
    logic                     fix_rem_ok;
    logic                     unused_bits;

    // Seed lookup on the incoming divisor's leading fraction bits.
    recip_seed_rom #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_seed (
        .idx  (y_sig[SIG_W-2 -: IDX_W]),
        .seed (seed)
    );

    // The one multiply-accumulate shared by every phase.
    recip_mac #(.W(MAC_W)) u_mac (
        .a   (mac_a),
        .b   (mac_b),
        .acc (mac_acc),
        .res (mac_res)
    );

    // Correction and rounding of the tentative quotient.
    recip_round #(.SIG_W(SIG_W), .REM_W(REM_W)) u_round (
        .qt      (qt_q),
        .rem     (rem_q),
        .dvsr    (y_q),
        .quo     (fix_quo),
        .inexact (fix_inexact),
        .rem_ok  (fix_rem_ok)
    );

    assign y_neg  = -$signed({{(MAC_W-SIG_W){1'b0}}, y_q});
    assign sh_err = mac_res >>> (SIG_W - 1);
    assign sh_upd = mac_res >>> FRAC_F;
    assign unused_bits = ^{sh_err[PROD_W-1:MAC_W], sh_upd[PROD_W-1:MAC_W],
                           mac_res[PROD_W-1:FRAC_F+SIG_W+1],
                           mac_res[FRAC_F-1:REM_W]};

    // Operand selection for the shared MAC per phase.
    always_comb begin
        mac_a   = '0;
        mac_b   = '0;
        mac_acc = '0;
        case (state)
            ST_ERR: begin
                mac_a   = t_q;
                mac_b   = y_neg;
                mac_acc = ONE_ERR;
            end
            ST_UPD: begin
                mac_a   = e_q;
                mac_b   = t_q;
                mac_acc = {{MAC_W{t_q[MAC_W-1]}}, t_q} <<< FRAC_F;
            end
            ST_QUO: begin
                mac_a   = t_q;
                mac_b   = {{(MAC_W-SIG_W-1){1'b0}}, x_q};
            end
            ST_REM: begin
                mac_a   = {{(MAC_W-SIG_W-1){1'b0}}, qt_q};
                mac_b   = y_neg;
                mac_acc = {{(PROD_W-SIG_W-1){1'b0}}, x_q} << (SIG_W - 1);
            end
            default: ;
        endcase
    end

    // Sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            iter_q  <= '0;
            x_q     <= '0;
            y_q     <= '0;
            below_q <= 1'b0;
            t_q     <= '0;
            e_q     <= '0;
            qt_q    <= '0;
            rem_q   <= '0;
            done    <= 1'b0;
            quo     <= '0;
            below   <= 1'b0;
            inexact <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        below_q <= (x_sig < y_sig);
                        x_q     <= (x_sig < y_sig) ? {x_sig, 1'b0} : {1'b0, x_sig};
                        y_q     <= y_sig;
                        t_q     <= {{(MAC_W-SEED_W){1'b0}}, seed} << (FRAC_F - SEED_W);
                        iter_q  <= '0;
                        state   <= ST_ERR;
                    end
                end
                ST_ERR: begin
                    e_q   <= sh_err[MAC_W-1:0];
                    state <= ST_UPD;
                end
                ST_UPD: begin
                    t_q <= sh_upd[MAC_W-1:0];
                    if (iter_q == LAST_IT) begin
                        state <= ST_QUO;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                        state  <= ST_ERR;
                    end
                end
                ST_QUO: begin
                    qt_q  <= mac_res[FRAC_F+SIG_W:FRAC_F];
                    state <= ST_REM;
                end
                ST_REM: begin
                    rem_q <= mac_res[REM_W-1:0];
                    state <= ST_FIX;
                end
                ST_FIX: begin
                    quo     <= fix_quo;
                    inexact <= fix_inexact;
                    below   <= below_q;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // Done never lasts beyond one cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A result cycle is never a busy cycle.
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // An accepted start makes the unit busy on the next edge.
    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // Published quotient is normalized.
    assert_quo_norm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> quo[SIG_W-1]);

    // Outputs hold between results.
    assert_quo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo) && $stable(inexact) && $stable(below)));

    // Refinement left the tentative quotient within one ulp: correction lands.
    assert_rem_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIX) |-> fix_rem_ok);

endmodule

// File: tb/recip_divider_bench.sv
module recip_divider_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 9;

    typedef struct {
        logic [23:0] q;
        logic        below;
        logic        inex;
        longint      cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] x_sig = 24'h800000;
    logic [23:0] y_sig = 24'h800000;
    logic        busy, done, below, inexact;
    logic [23:0] quo;

    exp_t   sb[$];
    longint cyc = 0;
    int     n_chk = 0;
    int     n_fail = 0;
    int     n_push = 0;
    int     n_done = 0;
    bit     finished = 0;
    logic [23:0] last_q = '0;

    recip_divider u_recip_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .x_sig(x_sig), .y_sig(y_sig),
        .busy(busy), .done(done), .quo(quo), .below(below), .inexact(inexact)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Reference from the requirements: integer nearest to N/y.
    function automatic exp_t model(input logic [23:0] xv, input logic [23:0] yv);
        exp_t   e;
        longint n, qq, rr;
        e.below = (xv < yv);
        n  = e.below ? (longint'(xv) << 24) : (longint'(xv) << 23);
        qq = n / longint'(yv);
        rr = n % longint'(yv);
        if (2 * rr > longint'(yv)) qq = qq + 1;
        e.q    = qq[23:0];
        e.inex = (rr != 0);
        e.cyc  = 0;
        return e;
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // Driver: issues one division and queues its expected result.
    task automatic run_op(input logic [23:0] xv, input logic [23:0] yv);
        exp_t e;
        wait_idle();
        e = model(xv, yv);
        e.cyc = cyc + 1;
        sb.push_back(e);
        n_push++;
        x_sig = xv;
        y_sig = yv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: pops the scoreboard on every done pulse.
    always @(negedge clk) begin
        if (rst_n && done && !finished) begin
            n_done++;
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quo == e.q, "R3 quotient", 64'(quo), 64'(e.q));
                check(quo[23], "R2 normalized", 64'(quo[23]), 64'd1);
                check(below == e.below, "R2 below flag", 64'(below), 64'(e.below));
                check(inexact == e.inex, "R5 inexact", 64'(inexact), 64'(e.inex));
                check(cyc - e.cyc == LATENCY, "R6 latency", 64'(cyc - e.cyc),
                      64'(LATENCY));
                check(!busy, "R7 busy low at done", 64'(busy), 64'd0);
                last_q = e.q;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        logic [31:0] rv;
        logic [23:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, done, below, inexact} == 4'b0, "R1 flags", 64'({busy, done, below, inexact}), 64'd0);
        check(quo == '0, "R1 quotient", 64'(quo), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy, "R1 idle after reset", 64'({busy, done}), 64'd0);

        // R4: exact quotients
        run_op(24'h800000, 24'h800000);
        run_op(24'hABCDEF, 24'hABCDEF);
        run_op(24'hFFFFFF, 24'h800000);
        run_op(24'hC00000, 24'h800000);
        run_op(24'h800000, 24'hC00000);   // R4/R5: 2/3 inexact, below
        run_op(24'h800000, 24'hFFFFFF);   // near-halfway, rounds up
        run_op(24'hFFFFFF, 24'h800001);
        run_op(24'h800001, 24'hFFFFFF);

        // R10: every seed-table entry
        for (int i = 0; i < 16; i++) begin
            rv = $urandom();
            run_op({1'b1, rv[22:0]}, {1'b1, 4'(i), 19'h2A5C3});
            run_op({1'b1, rv[30:8]}, {1'b1, 4'(i), 19'h7FFFF});
        end

        // R3: random operands
        for (int i = 0; i < 200; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            run_op({1'b1, ra[22:0]}, {1'b1, rb[22:0]});
        end

        // R8: start while busy is ignored
        run_op(24'h9A3F11, 24'hD0017B);
        check(busy, "R7 busy after start", 64'(busy), 64'd1);
        x_sig = 24'hFFFFFF;
        y_sig = 24'h800000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (15) @(negedge clk);
        check(n_done == n_push, "R8 no extra done", 64'(n_done), 64'(n_push));

        // R9: outputs hold while inputs wander
        held = quo;
        for (int i = 0; i < 6; i++) begin
            x_sig = 24'h800000 | 24'(i * 7919);
            y_sig = 24'hF00000 - 24'(i * 331);
            @(negedge clk);
            check(quo == held, "R9 hold", 64'(quo), 64'(held));
        end
        check(held == last_q, "R9 last result", 64'(held), 64'(last_q));
        check(sb.size() == 0, "R6 all results returned", 64'(sb.size()), 64'd0);
        summary();
    end

endmodule